// File: doc/BRIEF.md
# Interrupt Entry and Stack Sequencer

This block carries out the trap handling for a small 8-bit processor core. It holds one pending interrupt request, which may be a hardware reset, a non-maskable request or a maskable request. At each instruction boundary it either serves that request, serves a software break, or runs the return-from-interrupt sequence. An entry saves the return address and a packed status byte on a stack that stays inside one 256-byte page. It then reads a 16-bit handler vector from a fixed address and hands the new program counter and status back to the core.

The core shows an instruction boundary with a one-cycle strobe. It supplies its current program counter and packed status with that strobe. Each trap sequence makes exactly one byte access to memory per clock. A one-cycle completion pulse marks the moment the new program counter and status are valid. The stack pointer belongs to this block and can be observed from outside.

Top module: `trap_sequencer`

## Requirements
- R1: While in reset and just after it, the stack pointer reads 0xFF, the status output reads 0x2E, the program counter output reads 0x0000, and busy and done are low. A reset request is pending, so the first boundary runs the reset sequence.
- R2: A reset sequence makes no memory write. It reloads the stack pointer with 0xFF, reads the vector at 0xFFFC and then 0xFFFD, and ends with status 0x2E (0x28 with the zero and interrupt-disable bits set).
- R3: An entry writes the return address high byte, then its low byte, then the status byte. Each write goes to address 0x0100 plus the stack pointer, and the pointer then decrements, wrapping from 0x00 to 0xFF inside page 0x01.
- R4: The status byte packs carry in bit 0, zero in bit 1, interrupt-disable in bit 2, decimal in bit 3, break in bit 4, a constant one in bit 5, overflow in bit 6 and negative in bit 7. The pushed byte always has bit 5 set. Bit 4 is 1 for a break and 0 for a hardware interrupt.
- R5: Each vector is read low byte first. A non-maskable entry uses 0xFFFA/0xFFFB, and maskable and break entries share 0xFFFE/0xFFFF. The program counter becomes {high, low}. The status output becomes the pushed byte with bit 2 set.
- R6: A pending maskable request that meets a boundary while status bit 2 is set is discarded without any memory access and does not come back. A non-maskable request is served whatever bit 2 holds.
- R7: A new maskable request is ignored when any request is already pending. A non-maskable or reset request replaces the pending type.
- R8: When a request is served at a boundary, break and return strobes in the same cycle are ignored.
- R9: A return pulls the status, then the address low byte, then the high byte. Each pull first increments the stack pointer (wrapping 0xFF to 0x00) and then reads 0x0100 plus the pointer. The status output is the pulled byte with bit 5 forced to 1.
- R10: Busy is high exactly in the cycles that make one memory access each. Done is a one-cycle pulse in the cycle after the last access, and the program counter and status outputs hold their new values from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_irq_i | input | 1 | Maskable interrupt request strobe |
| req_nmi_i | input | 1 | Non-maskable interrupt request strobe |
| req_rst_i | input | 1 | Reset sequence request strobe |
| boundary_i | input | 1 | Instruction boundary strobe |
| brk_i | input | 1 | Software break at this boundary |
| rti_i | input | 1 | Return-from-interrupt at this boundary |
| pc_i | input | 16 | Return address from the core |
| status_i | input | 8 | Packed status from the core |
| mem_rdata_i | input | 8 | Read data, valid in the cycle the address is driven |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_wdata_o | output | 8 | Memory write data |
| pc_o | output | 16 | New program counter |
| status_o | output | 8 | New packed status |
| sp_o | output | 8 | Stack pointer (low byte inside page 0x01) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | New program counter and status valid (one cycle) |

## Verification
The assertions assume that boundary, break and return strobes come only while busy is low and that break and return are never raised together. They also assume that read data returns in the same cycle as its address. The stimulus drives each strobe for exactly one cycle and always waits for the done pulse before the next boundary. Request strobes are raised only between sequences, so a request never arrives in the cycle that consumes the pending one.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  localparam int FLAG_C   = 0;
  localparam int FLAG_Z   = 1;
  localparam int FLAG_I   = 2;
  localparam int FLAG_D   = 3;
  localparam int FLAG_B   = 4;
  localparam int FLAG_ONE = 5;
  localparam int FLAG_V   = 6;
  localparam int FLAG_N   = 7;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_IRQ  = 2'd1,
    PEND_NMI  = 2'd2,
    PEND_RST  = 2'd3
  } pend_e;

  typedef enum logic [2:0] {
    KIND_IRQ,
    KIND_NMI,
    KIND_RST,
    KIND_BRK,
    KIND_RTI
  } kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_ST,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_PULL_ST,
    ST_PULL_LO,
    ST_PULL_HI
  } state_e;
endpackage

// File: rtl/trap_pending.sv
module trap_pending
  import trap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  irq_i,
  input  logic  nmi_i,
  input  logic  rst_req_i,
  input  logic  consume_i,
  output pend_e pend_o
);
  pend_e pend_q, pend_d;
  logic  pend_en;

  assign pend_en = consume_i | irq_i | nmi_i | rst_req_i;

  always_comb begin
    pend_d = consume_i ? PEND_NONE : pend_q;
    if (rst_req_i)                         pend_d = PEND_RST;
    else if (nmi_i)                        pend_d = PEND_NMI;
    else if (irq_i && pend_q == PEND_NONE) pend_d = PEND_IRQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= PEND_RST;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R7: a maskable request never displaces a pending one
  assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != PEND_NONE && irq_i && !nmi_i && !rst_req_i && !consume_i)
      |=> (pend_q == $past(pend_q)));

  // R7: a non-maskable request takes over the pending slot
  assert_nmi_replaces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && !rst_req_i) |=> (pend_q == PEND_NMI));
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
  parameter int              PTR_W = 8,
  parameter logic [PTR_W-1:0] PAGE = 8'h01,
  parameter logic [PTR_W-1:0] TOP  = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               push_i,
  input  logic               pull_i,
  output logic [2*PTR_W-1:0] push_addr_o,
  output logic [2*PTR_W-1:0] pull_addr_o,
  output logic [PTR_W-1:0]   sp_o
);
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] sp_q, sp_d, sp_up;
  logic             sp_en;

  assign sp_up = sp_q + ONE;
  assign sp_en = load_i | push_i | pull_i;

  always_comb begin
    sp_d = sp_q;
    if (load_i)      sp_d = TOP;
    else if (push_i) sp_d = sp_q - ONE;
    else if (pull_i) sp_d = sp_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= TOP;
    else if (sp_en) sp_q <= sp_d;
  end

  assign push_addr_o = {PAGE, sp_q};
  assign pull_addr_o = {PAGE, sp_up};
  assign sp_o        = sp_q;

  // R3: a push moves the pointer down by one, modulo the page
  assert_push_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !load_i) |=> (sp_q == $past(sp_q) - ONE));

  // R9: a pull moves the pointer up by one, modulo the page
  assert_pull_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_i && !load_i && !push_i) |=> (sp_q == $past(sp_q) + ONE));

  // R3: at most one pointer operation per cycle
  assert_one_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_i, push_i, pull_i}));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [BYTE_W-1:0] RST_STATUS = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              brk_i,
  input  logic              rti_i,
  input  pend_e             pend_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [ADDR_W-1:0] pull_addr_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              consume_o,
  output logic              sp_load_o,
  output logic              sp_push_o,
  output logic              sp_pull_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              re_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [BYTE_W-1:0] MASK_I   = BYTE_W'(1) << FLAG_I;
  localparam logic [BYTE_W-1:0] MASK_ONE = BYTE_W'(1) << FLAG_ONE;
  localparam logic [ADDR_W-1:0] HI_SEL   = ADDR_W'(1);

  state_e            state_q, state_d;
  kind_e             kind_q, kind_d;
  logic [ADDR_W-1:0] ret_q, ret_d;
  logic [BYTE_W-1:0] work_q, work_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] vec_base;
  logic              masked;

  function automatic logic [BYTE_W-1:0] pack_entry(input logic [BYTE_W-1:0] s,
                                                   input logic brk);
    logic [BYTE_W-1:0] b;
    b           = s;
    b[FLAG_ONE] = 1'b1;
    b[FLAG_B]   = brk;
    return b;
  endfunction

  always_comb begin
    case (kind_q)
      KIND_NMI: vec_base = VEC_NMI;
      KIND_RST: vec_base = VEC_RST;
      default:  vec_base = VEC_IRQ;
    endcase
  end

  assign masked = (pend_i == PEND_IRQ) && status_i[FLAG_I];

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    ret_d     = ret_q;
    work_d    = work_q;
    lo_d      = lo_q;
    pc_d      = pc_q;
    stat_d    = stat_q;
    done_d    = 1'b0;
    consume_o = 1'b0;
    sp_load_o = 1'b0;
    sp_push_o = 1'b0;
    sp_pull_o = 1'b0;
    addr_o    = '0;
    we_o      = 1'b0;
    re_o      = 1'b0;
    wdata_o   = '0;
    case (state_q)
      ST_IDLE: begin
        if (boundary_i) begin
          consume_o = (pend_i != PEND_NONE);
          ret_d     = pc_i;
          if (pend_i != PEND_NONE && !masked) begin
            case (pend_i)
              PEND_NMI: kind_d = KIND_NMI;
              PEND_RST: kind_d = KIND_RST;
              default:  kind_d = KIND_IRQ;
            endcase
            if (pend_i == PEND_RST) begin
              sp_load_o = 1'b1;
              work_d    = RST_STATUS;
              state_d   = ST_VEC_LO;
            end else begin
              work_d  = pack_entry(status_i, 1'b0);
              state_d = ST_PUSH_HI;
            end
          end else if (brk_i) begin
            kind_d  = KIND_BRK;
            work_d  = pack_entry(status_i, 1'b1);
            state_d = ST_PUSH_HI;
          end else if (rti_i) begin
            kind_d  = KIND_RTI;
            state_d = ST_PULL_ST;
          end
        end
      end
      ST_PUSH_HI: begin
        we_o      = 1'b1;
        addr_o    = push_addr_i;
        wdata_o   = ret_q[ADDR_W-1:BYTE_W];
        sp_push_o = 1'b1;
        state_d   = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        we_o      = 1'b1;
        addr_o    = push_addr_i;
        wdata_o   = ret_q[BYTE_W-1:0];
        sp_push_o = 1'b1;
        state_d   = ST_PUSH_ST;
      end
      ST_PUSH_ST: begin
        we_o      = 1'b1;
        addr_o    = push_addr_i;
        wdata_o   = work_q;
        sp_push_o = 1'b1;
        state_d   = ST_VEC_LO;
      end
      ST_VEC_LO: begin
        re_o    = 1'b1;
        addr_o  = vec_base;
        lo_d    = rdata_i;
        state_d = ST_VEC_HI;
      end
      ST_VEC_HI: begin
        re_o    = 1'b1;
        addr_o  = vec_base | HI_SEL;
        pc_d    = {rdata_i, lo_q};
        stat_d  = work_q | MASK_I;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_PULL_ST: begin
        re_o      = 1'b1;
        addr_o    = pull_addr_i;
        sp_pull_o = 1'b1;
        work_d    = rdata_i;
        state_d   = ST_PULL_LO;
      end
      ST_PULL_LO: begin
        re_o      = 1'b1;
        addr_o    = pull_addr_i;
        sp_pull_o = 1'b1;
        lo_d      = rdata_i;
        state_d   = ST_PULL_HI;
      end
      ST_PULL_HI: begin
        re_o      = 1'b1;
        addr_o    = pull_addr_i;
        sp_pull_o = 1'b1;
        pc_d      = {rdata_i, lo_q};
        stat_d    = work_q | MASK_ONE;
        done_d    = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_IRQ;
      ret_q   <= '0;
      work_q  <= '0;
      lo_q    <= '0;
      pc_q    <= '0;
      stat_q  <= RST_STATUS | MASK_I;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      ret_q   <= ret_d;
      work_q  <= work_d;
      lo_q    <= lo_d;
      pc_q    <= pc_d;
      stat_q  <= stat_d;
      done_q  <= done_d;
    end
  end

  assign pc_o     = pc_q;
  assign status_o = stat_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  // R10: every busy cycle makes exactly one memory access
  assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (we_o ^ re_o));

  // R10: completion lasts a single cycle and follows the last access
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R2: the reset sequence never writes memory
  assert_rst_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && kind_q == KIND_RST) |-> !we_o);

  // R5: every entry leaves interrupts disabled
  assert_entry_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_q != KIND_RTI) |-> status_o[FLAG_I]);

  // R6: a masked maskable request starts no sequence
  assert_masked_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && boundary_i && masked && !brk_i && !rti_i) |=> !busy_o);

  // R4: the pushed status byte carries the constant-one bit
  assert_bit5_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && state_q == ST_PUSH_ST) |-> wdata_o[FLAG_ONE]);
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [BYTE_W-1:0] STACK_TOP  = 8'hFF,
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [BYTE_W-1:0] RST_STATUS = 8'h2A,
  parameter int                SYNC_LEN   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_irq_i,
  input  logic        req_nmi_i,
  input  logic        req_rst_i,
  input  logic        boundary_i,
  input  logic        brk_i,
  input  logic        rti_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  status_i,
  input  logic [7:0]  mem_rdata_i,
  output logic [15:0] mem_addr_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [7:0]  mem_wdata_o,
  output logic [15:0] pc_o,
  output logic [7:0]  status_o,
  output logic [7:0]  sp_o,
  output logic        busy_o,
  output logic        done_o
);
  logic [SYNC_LEN-1:0] rsync_q;
  logic                rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_n_s = rsync_q[SYNC_LEN-1];

  pend_e             pend;
  logic              consume, sp_load, sp_push, sp_pull;
  logic [ADDR_W-1:0] push_addr, pull_addr;

  trap_pending u_pending (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .irq_i     (req_irq_i),
    .nmi_i     (req_nmi_i),
    .rst_req_i (req_rst_i),
    .consume_i (consume),
    .pend_o    (pend)
  );

  trap_stack #(
    .PTR_W (BYTE_W),
    .PAGE  (STACK_PAGE),
    .TOP   (STACK_TOP)
  ) u_stack (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .load_i      (sp_load),
    .push_i      (sp_push),
    .pull_i      (sp_pull),
    .push_addr_o (push_addr),
    .pull_addr_o (pull_addr),
    .sp_o        (sp_o)
  );

  trap_ctrl #(
    .VEC_NMI    (VEC_NMI),
    .VEC_RST    (VEC_RST),
    .VEC_IRQ    (VEC_IRQ),
    .RST_STATUS (RST_STATUS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .boundary_i  (boundary_i),
    .brk_i       (brk_i),
    .rti_i       (rti_i),
    .pend_i      (pend),
    .pc_i        (pc_i),
    .status_i    (status_i),
    .push_addr_i (push_addr),
    .pull_addr_i (pull_addr),
    .rdata_i     (mem_rdata_i),
    .consume_o   (consume),
    .sp_load_o   (sp_load),
    .sp_push_o   (sp_push),
    .sp_pull_o   (sp_pull),
    .addr_o      (mem_addr_o),
    .we_o        (mem_we_o),
    .re_o        (mem_re_o),
    .wdata_o     (mem_wdata_o),
    .pc_o        (pc_o),
    .status_o    (status_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );
endmodule

// File: tb/trap_sequencer_tb_top.sv
module trap_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_irq = 1'b0, req_nmi = 1'b0, req_rst = 1'b0;
  logic        boundary = 1'b0, brk = 1'b0, rti = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  st_in = 8'h00;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [15:0] pc_out;
  logic [7:0]  st_out, sp_out;
  logic        busy, done;

  always #4 clk = ~clk;

  trap_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .req_irq_i(req_irq), .req_nmi_i(req_nmi),
    .req_rst_i(req_rst), .boundary_i(boundary), .brk_i(brk), .rti_i(rti),
    .pc_i(pc_in), .status_i(st_in), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .pc_o(pc_out), .status_o(st_out), .sp_o(sp_out),
    .busy_o(busy), .done_o(done)
  );

  // memory: stack page plus six vector bytes
  logic [7:0] stk [256];

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (a[15:8] == 8'h01) return stk[a[7:0]];
    case (a)
      16'hFFFA: return 8'hB2;
      16'hFFFB: return 8'hA1;
      16'hFFFC: return 8'hD4;
      16'hFFFD: return 8'hC3;
      16'hFFFE: return 8'hF6;
      16'hFFFF: return 8'hE5;
      default:  return 8'h00;
    endcase
  endfunction

  always_comb mem_rdata = rd(mem_addr);

  always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model
  typedef struct packed {
    logic        we;
    logic        re;
    logic [15:0] addr;
    logic [7:0]  wd;
  } acc_t;

  acc_t        exp_q[$];
  int          m_pend;
  logic [7:0]  m_sp;
  logic [15:0] m_pc;
  logic [7:0]  m_st;
  bit          mon_en = 1'b0;

  // R10: per-clock comparison of bus activity against the model
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_q.size() > 0) begin
        acc_t e;
        logic [26:0] a_v, e_v;
        e   = exp_q.pop_front();
        a_v = {busy, mem_we, mem_re, mem_addr, mem_we ? mem_wdata : 8'h00};
        e_v = {1'b1, e.we, e.re, e.addr, e.we ? e.wd : 8'h00};
        chk(a_v == e_v, "R10", "bus cycle", 32'(a_v), 32'(e_v));
      end else begin
        chk({busy, mem_we, mem_re} == 3'b000, "R10", "idle bus",
            32'({busy, mem_we, mem_re}), 32'h0);
      end
    end
  end

  task automatic raise(input int k);
    @(negedge clk);
    req_irq = (k == 1);
    req_nmi = (k == 2);
    req_rst = (k == 3);
    @(posedge clk);
    #1;
    req_irq = 1'b0; req_nmi = 1'b0; req_rst = 1'b0;
    if (k == 1) begin
      if (m_pend == 0) m_pend = 1;
    end else m_pend = k;
  endtask

  task automatic push_exp(input logic [7:0] d);
    exp_q.push_back('{we: 1'b1, re: 1'b0, addr: {8'h01, m_sp}, wd: d});
    m_sp = m_sp - 8'd1;
  endtask

  task automatic read_exp(input logic [15:0] a);
    exp_q.push_back('{we: 1'b0, re: 1'b1, addr: a, wd: 8'h00});
  endtask

  // kinds: 1 maskable, 2 non-maskable, 3 reset, 4 break, 5 return
  task automatic step(input bit b, input bit r, input string req);
    int kind = 0;
    int n;
    logic [7:0]  pb, v, lo, hi;
    logic [15:0] vb;
    if (m_pend == 1 && st_in[2]) m_pend = 0;
    if (m_pend != 0) begin kind = m_pend; m_pend = 0; end
    else if (b) kind = 4;
    else if (r) kind = 5;
    @(negedge clk);
    boundary = 1'b1; brk = b; rti = r;
    @(posedge clk);
    #1;
    boundary = 1'b0; brk = 1'b0; rti = 1'b0;
    if (kind == 1 || kind == 2 || kind == 4) begin
      pb = st_in | 8'h20;
      pb[4] = (kind == 4);
      push_exp(pc_in[15:8]);
      push_exp(pc_in[7:0]);
      push_exp(pb);
      vb = (kind == 2) ? 16'hFFFA : 16'hFFFE;
      read_exp(vb);
      read_exp(vb + 16'd1);
      m_pc = {rd(vb + 16'd1), rd(vb)};
      m_st = pb | 8'h04;
    end else if (kind == 3) begin
      m_sp = 8'hFF;
      read_exp(16'hFFFC);
      read_exp(16'hFFFD);
      m_pc = {rd(16'hFFFD), rd(16'hFFFC)};
      m_st = 8'h2E;
    end else if (kind == 5) begin
      m_sp = m_sp + 8'd1; read_exp({8'h01, m_sp}); v  = stk[m_sp];
      m_sp = m_sp + 8'd1; read_exp({8'h01, m_sp}); lo = stk[m_sp];
      m_sp = m_sp + 8'd1; read_exp({8'h01, m_sp}); hi = stk[m_sp];
      m_pc = {hi, lo};
      m_st = v | 8'h20;
    end
    n = exp_q.size();
    if (kind != 0) begin
      repeat (n) @(negedge clk);
      @(negedge clk);
      chk(done == 1'b1, req, "done pulse", 32'(done), 32'h1);
      chk(pc_out == m_pc, req, "pc", 32'(pc_out), 32'(m_pc));
      chk(st_out == m_st, req, "status", 32'(st_out), 32'(m_st));
      chk(sp_out == m_sp, req, "sp", 32'(sp_out), 32'(m_sp));
      @(negedge clk);
      chk(done == 1'b0, "R10", "done length", 32'(done), 32'h0);
    end else begin
      repeat (2) @(negedge clk);
      chk(done == 1'b0 && pc_out == m_pc && st_out == m_st && sp_out == m_sp,
          req, "no sequence", 32'({pc_out, st_out, sp_out}), 32'({m_pc, m_st, m_sp}));
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'(i) ^ 8'h5C;
    m_pend = 3; m_sp = 8'hFF; m_pc = 16'h0000; m_st = 8'h2E;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({busy, done, sp_out, st_out, pc_out} == {2'b00, 8'hFF, 8'h2E, 16'h0000},
        "R1", "reset state", 32'({busy, done, sp_out, st_out}), 32'({2'b00, 8'hFF, 8'h2E}));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, sp_out, st_out} == {2'b00, 8'hFF, 8'h2E},
        "R1", "after release", 32'({busy, done, sp_out, st_out}), 32'({2'b00, 8'hFF, 8'h2E}));
    mon_en = 1'b1;

    // R1/R2: pending reset served at first boundary
    step(1'b0, 1'b0, "R2");

    // R6: masked maskable request discarded and not retained
    st_in = 8'h04; pc_in = 16'h1234;
    raise(1);
    step(1'b0, 1'b0, "R6");
    st_in = 8'h00;
    step(1'b0, 1'b0, "R6");

    // R5: maskable entry, pushes and vector
    st_in = 8'hC3; pc_in = 16'h8123;
    raise(1);
    step(1'b0, 1'b0, "R5");

    // R9: return with bit 5 cleared in the saved status
    stk[m_sp + 8'd1] = 8'h5A;
    step(1'b0, 1'b1, "R9");

    // R4: break sets bit 4 in the pushed byte
    st_in = 8'h00; pc_in = 16'h4455;
    step(1'b1, 1'b0, "R4");

    // R6: non-maskable served while interrupt-disable set
    st_in = 8'h04; pc_in = 16'h0A0B;
    raise(2);
    step(1'b0, 1'b0, "R6");

    // R7: non-maskable replaces pending maskable
    st_in = 8'h00; pc_in = 16'h2222;
    raise(1); raise(2);
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");

    // R7: maskable ignored while non-maskable pending
    pc_in = 16'h3333;
    raise(2); raise(1);
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");

    // R8: pending request wins over a break strobe
    pc_in = 16'h5151;
    raise(2);
    step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, "R8");

    // R2: reset request mid-run reloads the pointer
    raise(3);
    step(1'b0, 1'b0, "R2");

    // R9: return with pointer at 0xFF wraps to page start
    step(1'b0, 1'b1, "R9");

    // R3: repeated breaks wrap the pointer around the page
    raise(3);
    step(1'b0, 1'b0, "R2");
    for (int i = 0; i < 90; i++) begin
      pc_in = 16'(i * 16'h0107);
      st_in = 8'(i) & 8'hCF;
      step(1'b1, 1'b0, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule